// File: doc/BRIEF.md
# ADC System Calibration Sequencer

This block is the control side of a sigma-delta converter's system calibration. A host writes a 3-bit mode value together with a channel number. Two codes launch a calibration. Code 3'b110 measures the system zero point, and code 3'b111 measures the system full-scale point. The block then waits for the modulator to acknowledge and raises a ready flag. It counts output-rate ticks for a length that depends on the chop setting. On the last tick it stores the converter's result word into the chosen channel's offset or gain coefficient. It then drops ready and sets the mode back to idle.

The block enforces two rules on calibration order. A full-scale step is refused on a channel that has no valid zero-scale coefficient. A full-scale measurement whose span exceeds the allowed headroom is also refused. Either refusal sets a sticky error flag and leaves the coefficient unchanged. Conversion and idle codes are stored as written and start nothing here. A calibration never produces a conversion result.

Top module: `adc_cal_seq`

## Requirements
- R1: A write of 3'b110 while no calibration is pending or running starts a zero-scale calibration. From the next cycle, mode_out reads 3'b110 and ready stays low. Ready rises in the cycle after the first mod_tick that follows the command, so it lags the command by at most one modulator period.
- R2: A write of 3'b111 starts a full-scale calibration with the same timing as R1, but only if the selected channel's offset_valid bit is 1. While ready is high, mode_out reads 3'b110 or 3'b111.
- R3: The length is counted only in rate_tick pulses that arrive after ready has risen. It is 22 pulses when chop_en was 1 at the command and 24 pulses when chop_en was 0. Ready is still high after pulse N-1. Ticks that arrive while the calibration is pending are not counted.
- R4: In the cycle after the final rate_tick, ready is 0 and mode_out is 3'b000.
- R5: A zero-scale calibration writes offset[ch] = result - Z, with Z = 0 when bipolar was 0 at the command and Z = 2^(DATA_W-1) when bipolar was 1. It also sets offset_valid[ch]. No other coefficient changes.
- R6: A full-scale calibration computes span = result - offset[ch], modulo 2^DATA_W. The limit is floor(((FS_BASE << range_sel) * 21) / 20), taking range_sel at the command. If span is at most the limit, gain[ch] becomes span. Otherwise gain[ch] is unchanged and cal_err is set.
- R7: A 3'b111 write on a channel whose offset_valid bit is 0 is refused. Mode_out becomes 3'b000, ready stays low even after later mod_tick pulses, and cal_err becomes 1 and stays 1 until reset.
- R8: While idle, a write of any code other than 3'b110 and 3'b111 (for example 3'b001, 3'b010 or 3'b000) is copied to mode_out and leaves ready low.
- R9: While a calibration is pending or running, mode writes are ignored. This includes a write in the same cycle as the final rate_tick.
- R10: After reset, ready is 0, mode_out is 3'b000, cal_err is 0, and every offset, gain and offset_valid bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | Mode write strobe |
| mode_in | input | 3 | Mode code written |
| ch_sel | input | CH_W | Channel for the written mode |
| chop_en | input | 1 | Chop setting, selects calibration length |
| bipolar | input | 1 | Bipolar input range selects midpoint zero |
| range_sel | input | 2 | Nominal input range select |
| mod_tick | input | 1 | One pulse per modulator period |
| rate_tick | input | 1 | One pulse per output-rate period |
| result | input | DATA_W | Converter measurement word |
| ready | output | 1 | High while a calibration is running |
| mode_out | output | 3 | Current mode field |
| cal_err | output | 1 | Sticky calibration refusal flag |
| offset_valid | output | NUM_CH | Per-channel zero-scale valid bits |
| offset_flat | output | NUM_CH*DATA_W | Offset coefficients, channel c at [c*DATA_W +: DATA_W] |
| gain_flat | output | NUM_CH*DATA_W | Gain coefficients, same packing |

## Verification
Two events can land in the same clock cycle: the completion of a calibration on its final rate_tick, and a host mode write. The bench drives a 3'b001 write together with the last tick and checks three things: the coefficient is stored, mode_out ends at 3'b000 rather than 3'b001, and ready falls. A second coincidence is tested as well. Rate ticks are issued during the pending window, before mod_tick. The bench confirms they do not shorten the calibration by checking that ready is still high after N-1 counted ticks.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PEND = 2'd1,
    ST_RUN  = 2'd2
  } cal_state_t;

  localparam logic [2:0] MODE_IDLE   = 3'b000;
  localparam logic [2:0] MODE_SYS_ZS = 3'b110;
  localparam logic [2:0] MODE_SYS_FS = 3'b111;

  // code that represents zero input: bottom for unipolar, midpoint for bipolar
  function automatic logic [31:0] zero_point(input logic bip, input int unsigned width);
    return bip ? (32'd1 << (width - 1)) : 32'd0;
  endfunction

  // largest accepted span: nominal range plus five percent
  function automatic logic [31:0] fs_ceiling(input logic [31:0] base, input logic [1:0] rng);
    logic [31:0] nominal;
    nominal = base << rng;
    return (nominal * 32'd21) / 32'd20;
  endfunction

  // number of output-rate periods a calibration lasts
  function automatic int unsigned cal_len(input logic chop, input int unsigned chop_len,
                                          input int unsigned plain_len);
    return chop ? chop_len : plain_len;
  endfunction

endpackage

// File: rtl/cal_mode_dec.sv
module cal_mode_dec
  import adc_cal_pkg::*;
(
  input  logic       mode_wr,
  input  logic [2:0] mode_in,
  input  logic       busy,
  input  logic       sel_valid,
  output logic       start_zs,
  output logic       start_fs,
  output logic       fs_reject,
  output logic       plain_wr
);

  logic accept;
  logic is_zs;
  logic is_fs;

  assign accept    = mode_wr && !busy;
  assign is_zs     = (mode_in == MODE_SYS_ZS);
  assign is_fs     = (mode_in == MODE_SYS_FS);
  assign start_zs  = accept && is_zs;
  assign start_fs  = accept && is_fs && sel_valid;
  assign fs_reject = accept && is_fs && !sel_valid;
  assign plain_wr  = accept && !is_zs && !is_fs;

endmodule

// File: rtl/cal_ctrl.sv
module cal_ctrl
  import adc_cal_pkg::*;
#(
  parameter int unsigned CHOP_LEN  = 22,
  parameter int unsigned PLAIN_LEN = 24,
  localparam int unsigned MAX_LEN  = (CHOP_LEN > PLAIN_LEN) ? CHOP_LEN : PLAIN_LEN,
  localparam int unsigned CNT_W    = $clog2(MAX_LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic chop_en,
  input  logic mod_tick,
  input  logic rate_tick,
  output logic busy,
  output logic running,
  output logic done_evt
);

  cal_state_t       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] len_q;
  logic             rise_evt;

  assign busy     = (state_q != ST_IDLE);
  assign running  = (state_q == ST_RUN);
  assign rise_evt = (state_q == ST_PEND) && mod_tick;
  assign done_evt = running && rate_tick && (cnt_q == len_q - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      len_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) begin
          state_q <= ST_PEND;
          len_q   <= CNT_W'(cal_len(chop_en, CHOP_LEN, PLAIN_LEN));
          cnt_q   <= '0;
        end
        ST_PEND: if (rise_evt) begin
          state_q <= ST_RUN;
          cnt_q   <= '0;
        end
        ST_RUN: if (done_evt) begin
          state_q <= ST_IDLE;
        end else if (rate_tick) begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R1
  ready_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> $past(mod_tick));

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (cnt_q < len_q));

  // R9
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);

endmodule

// File: rtl/cal_coef_bank.sv
module cal_coef_bank #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned DATA_W = 24,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     off_we,
  input  logic                     gain_we,
  input  logic [CH_W-1:0]          wr_ch,
  input  logic [DATA_W-1:0]        off_wdata,
  input  logic [DATA_W-1:0]        gain_wdata,
  input  logic [CH_W-1:0]          rd_ch,
  output logic [DATA_W-1:0]        rd_offset,
  output logic                     rd_valid,
  output logic [NUM_CH-1:0]        valid,
  output logic [NUM_CH*DATA_W-1:0] offset_flat,
  output logic [NUM_CH*DATA_W-1:0] gain_flat
);

  logic [DATA_W-1:0] off_q  [NUM_CH];
  logic [DATA_W-1:0] gain_q [NUM_CH];
  logic [NUM_CH-1:0] valid_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    assign hit = (wr_ch == CH_W'(c));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        off_q[c]   <= '0;
        gain_q[c]  <= '0;
        valid_q[c] <= 1'b0;
      end else begin
        if (off_we && hit) begin
          off_q[c]   <= off_wdata;
          valid_q[c] <= 1'b1;
        end
        if (gain_we && hit) gain_q[c] <= gain_wdata;
      end
    end
    assign offset_flat[c*DATA_W +: DATA_W] = off_q[c];
    assign gain_flat[c*DATA_W +: DATA_W]   = gain_q[c];
  end

  assign valid     = valid_q;
  assign rd_offset = off_q[rd_ch];
  assign rd_valid  = valid_q[rd_ch];

  // R5
  one_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(off_we && gain_we));

  // R2
  gain_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gain_we |-> valid_q[wr_ch]);

endmodule

// File: rtl/adc_cal_seq.sv
module adc_cal_seq
  import adc_cal_pkg::*;
#(
  parameter int unsigned NUM_CH    = 4,
  parameter int unsigned DATA_W    = 24,
  parameter int unsigned CHOP_LEN  = 22,
  parameter int unsigned PLAIN_LEN = 24,
  parameter int unsigned FS_BASE   = 10000,
  localparam int unsigned CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     mode_wr,
  input  logic [2:0]               mode_in,
  input  logic [CH_W-1:0]          ch_sel,
  input  logic                     chop_en,
  input  logic                     bipolar,
  input  logic [1:0]               range_sel,
  input  logic                     mod_tick,
  input  logic                     rate_tick,
  input  logic [DATA_W-1:0]        result,
  output logic                     ready,
  output logic [2:0]               mode_out,
  output logic                     cal_err,
  output logic [NUM_CH-1:0]        offset_valid,
  output logic [NUM_CH*DATA_W-1:0] offset_flat,
  output logic [NUM_CH*DATA_W-1:0] gain_flat
);

  logic              start_zs, start_fs, fs_reject, plain_wr;
  logic              busy, running, done_evt;
  logic              sel_valid, rd_valid;
  logic [CH_W-1:0]   ch_q;
  logic              kind_fs_q, bip_q;
  logic [1:0]        rng_q;
  logic [2:0]        mode_q;
  logic              err_q;
  logic [DATA_W-1:0] cur_offset, span, off_wdata;
  logic              span_ok, off_we, gain_we, fs_over;
  logic [CH_W-1:0]   rd_ch;

  // while idle look at the channel being written, otherwise the latched one
  assign rd_ch = busy ? ch_q : ch_sel;

  cal_mode_dec u_dec (
    .mode_wr  (mode_wr),
    .mode_in  (mode_in),
    .busy     (busy),
    .sel_valid(sel_valid),
    .start_zs (start_zs),
    .start_fs (start_fs),
    .fs_reject(fs_reject),
    .plain_wr (plain_wr)
  );

  cal_ctrl #(.CHOP_LEN(CHOP_LEN), .PLAIN_LEN(PLAIN_LEN)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_zs || start_fs),
    .chop_en  (chop_en),
    .mod_tick (mod_tick),
    .rate_tick(rate_tick),
    .busy     (busy),
    .running  (running),
    .done_evt (done_evt)
  );

  assign span      = result - cur_offset;
  assign span_ok   = (32'(span) <= fs_ceiling(32'(FS_BASE), rng_q));
  assign off_wdata = result - DATA_W'(zero_point(bip_q, DATA_W));
  assign off_we    = done_evt && !kind_fs_q;
  assign gain_we   = done_evt && kind_fs_q && span_ok;
  assign fs_over   = done_evt && kind_fs_q && !span_ok;
  assign sel_valid = rd_valid;

  cal_coef_bank #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .off_we     (off_we),
    .gain_we    (gain_we),
    .wr_ch      (ch_q),
    .off_wdata  (off_wdata),
    .gain_wdata (span),
    .rd_ch      (rd_ch),
    .rd_offset  (cur_offset),
    .rd_valid   (rd_valid),
    .valid      (offset_valid),
    .offset_flat(offset_flat),
    .gain_flat  (gain_flat)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ch_q      <= '0;
      kind_fs_q <= 1'b0;
      bip_q     <= 1'b0;
      rng_q     <= '0;
      mode_q    <= MODE_IDLE;
      err_q     <= 1'b0;
    end else begin
      if (start_zs || start_fs) begin
        ch_q      <= ch_sel;
        kind_fs_q <= start_fs;
        bip_q     <= bipolar;
        rng_q     <= range_sel;
        mode_q    <= mode_in;
      end else if (plain_wr) begin
        mode_q <= mode_in;
      end else if (fs_reject || done_evt) begin
        mode_q <= MODE_IDLE;
      end
      if (fs_reject || fs_over) err_q <= 1'b1;
    end
  end

  assign ready    = running;
  assign mode_out = mode_q;
  assign cal_err  = err_q;

  // R2
  ready_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (mode_out[2:1] == 2'b11));

  // R4
  idle_after_cal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> (mode_out == MODE_IDLE));

  // R7
  reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fs_reject |=> (!ready && mode_out == MODE_IDLE && cal_err));

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_err |=> cal_err);

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done_evt) |=> $stable(mode_out));

endmodule

// File: tb/adc_cal_seq_tb.sv
module adc_cal_seq_tb;

  localparam int NCH = 4;
  localparam int DW  = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_wr = 1'b0;
  logic [2:0] mode_in = 3'b000;
  logic [1:0] ch_sel = '0;
  logic chop_en = 1'b0, bipolar = 1'b0;
  logic [1:0] range_sel = '0;
  logic mod_tick = 1'b0, rate_tick = 1'b0;
  logic [DW-1:0] result = '0;
  logic ready, cal_err;
  logic [2:0] mode_out;
  logic [NCH-1:0] offset_valid;
  logic [NCH*DW-1:0] offset_flat, gain_flat;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] m_off [NCH];
  logic [DW-1:0] m_gain [NCH];
  logic [NCH-1:0] m_val;
  logic m_err;

  always #10 clk = ~clk;

  adc_cal_seq u_dut (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_in(mode_in), .ch_sel(ch_sel),
    .chop_en(chop_en), .bipolar(bipolar), .range_sel(range_sel), .mod_tick(mod_tick),
    .rate_tick(rate_tick), .result(result), .ready(ready), .mode_out(mode_out),
    .cal_err(cal_err), .offset_valid(offset_valid), .offset_flat(offset_flat),
    .gain_flat(gain_flat)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_bank(input string req);
    for (int c = 0; c < NCH; c++) begin
      chk(req, 32'(offset_flat[c*DW +: DW]), 32'(m_off[c]));
      chk(req, 32'(gain_flat[c*DW +: DW]), 32'(m_gain[c]));
    end
    chk(req, 32'(offset_valid), 32'(m_val));
    chk(req, 32'(cal_err), 32'(m_err));
  endtask

  task automatic write_mode(input logic [2:0] m, input logic [1:0] ch);
    mode_in = m; ch_sel = ch; mode_wr = 1'b1;
    step();
    mode_wr = 1'b0;
  endtask

  // runs one calibration, checking lag, length, completion and coefficients
  task automatic do_cal(input logic [2:0] m, input logic [1:0] ch, input logic chop,
                        input logic bip, input logic [1:0] rng, input logic [DW-1:0] res,
                        input logic early_ticks, input logic busy_wr);
    int n;
    logic [DW-1:0] span;
    logic [31:0] lim;
    n = chop ? 22 : 24;
    chop_en = chop; bipolar = bip; range_sel = rng;
    write_mode(m, ch);
    chop_en = ~chop; bipolar = ~bip; range_sel = ~rng;
    chk("R1 mode after command", 32'(mode_out), 32'(m));
    chk("R1 ready waits for mod_tick", 32'(ready), 0);
    if (early_ticks) begin
      for (int i = 0; i < 3; i++) begin
        rate_tick = 1'b1; step(); rate_tick = 1'b0;
      end
    end
    if (busy_wr) begin
      write_mode(3'b001, ch);
      chk("R9 write while pending ignored", 32'(mode_out), 32'(m));
    end
    step();
    chk("R1 ready low before mod_tick", 32'(ready), 0);
    mod_tick = 1'b1; step(); mod_tick = 1'b0;
    chk("R1 ready after mod_tick", 32'(ready), 1);
    for (int i = 0; i < n; i++) begin
      if (i == n - 1) begin
        result = res;
        if (busy_wr) begin mode_wr = 1'b1; mode_in = 3'b001; end
      end
      rate_tick = 1'b1; step(); rate_tick = 1'b0; mode_wr = 1'b0;
      if (i == n - 2) chk("R3 still running after N-1 ticks", 32'(ready), 1);
      else if (i < n - 1) step();
    end
    chk("R4 ready falls at end", 32'(ready), 0);
    chk(busy_wr ? "R9 coincident write dropped" : "R4 mode back to idle", 32'(mode_out), 0);
    if (m == 3'b110) begin
      m_off[ch] = res - (bip ? DW'(1) << (DW-1) : '0);
      m_val[ch] = 1'b1;
    end else begin
      span = res - m_off[ch];
      lim = ((32'd10000 << rng) * 32'd21) / 32'd20;
      if (32'(span) <= lim) m_gain[ch] = span;
      else m_err = 1'b1;
    end
    check_bank(m == 3'b110 ? "R5 coefficients" : "R6 coefficients");
  endtask

  task automatic test_reset();
    chk("R10 ready", 32'(ready), 0);
    chk("R10 mode", 32'(mode_out), 0);
    check_bank("R10 bank");
  endtask

  task automatic test_zs_unipolar();
    do_cal(3'b110, 2'd1, 1'b1, 1'b0, 2'd0, 24'd100, 1'b0, 1'b0);
  endtask

  task automatic test_zs_bipolar_early_ticks();
    do_cal(3'b110, 2'd2, 1'b0, 1'b1, 2'd0, 24'h800010, 1'b1, 1'b0);
  endtask

  task automatic test_fs_invalid();
    write_mode(3'b111, 2'd3);
    m_err = 1'b1;
    chk("R7 mode idle on reject", 32'(mode_out), 0);
    chk("R7 ready low on reject", 32'(ready), 0);
    mod_tick = 1'b1; step(); mod_tick = 1'b0;
    chk("R7 ready stays low", 32'(ready), 0);
    check_bank("R7 bank");
  endtask

  task automatic test_fs_bounds();
    do_cal(3'b111, 2'd1, 1'b1, 1'b0, 2'd0, 24'd10600, 1'b0, 1'b0);  // span exactly 10500
    chk("R2 gain at limit", 32'(gain_flat[1*DW +: DW]), 32'd10500);
    do_cal(3'b111, 2'd1, 1'b0, 1'b0, 2'd0, 24'd10601, 1'b0, 1'b0);  // one above
    chk("R6 over limit keeps gain", 32'(gain_flat[1*DW +: DW]), 32'd10500);
    do_cal(3'b111, 2'd2, 1'b1, 1'b0, 2'd3, 24'd84016, 1'b0, 1'b1);  // range 3, limit 84000
  endtask

  task automatic test_plain_writes();
    write_mode(3'b001, 2'd0);
    chk("R8 conversion code stored", 32'(mode_out), 32'd1);
    write_mode(3'b010, 2'd0);
    chk("R8 second conversion code", 32'(mode_out), 32'd2);
    mod_tick = 1'b1; step(); mod_tick = 1'b0;
    chk("R8 no ready for conversion", 32'(ready), 0);
    write_mode(3'b000, 2'd0);
    chk("R8 idle code stored", 32'(mode_out), 32'd0);
    check_bank("R8 bank");
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) begin m_off[c] = '0; m_gain[c] = '0; end
    m_val = '0; m_err = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_zs_unipolar();
    test_zs_bipolar_early_ticks();
    test_fs_invalid();
    test_plain_writes();
    test_fs_bounds();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule